// File: doc/BRIEF.md
# Addressed Single-Bit Configuration Store

This block holds a row of single-bit configuration cells that downstream logic (multiplexer selects, lookup entries, pad modes) reads continuously. Bits are loaded one at a time. On each clock the writer presents an enable, a binary cell address and one data bit. An internal decoder raises the word-line of the addressed cell only, and only while enable is high. The data bit goes to every cell as a shared bit-line. Only the selected cell takes it in on the rising clock edge. Every other cell keeps its value.

Each cell drives a true output and a complemented output, so there are two N-bit buses. When a build parameter turns it on, the decoder's word-lines also leave the block as an active-low bus. Frame chaining, readback and the controller that drives the port belong to other blocks. The write port has no back-pressure. There is no ready signal, and the block accepts every cycle in which enable is high. Writes to addresses with no cell behind them are dropped without any effect.

Top module: `cfgmem_frame`

## Requirements
- R1: While `rst_n` is low, every cell reads 0: `cell_q` is all zeros and `cell_qn` is all ones.
- R2: With `wr_en` high and `wr_addr` (binary, cell index) below `NUM_CELLS`, the bit `cell_q[wr_addr]` equals `wr_bit` after the next rising clock edge.
- R3: A write changes no cell other than the addressed one, so at most one bit of `cell_q` changes per clock.
- R4: With `wr_en` low, no cell changes, whatever the values of `wr_addr` and `wr_bit`.
- R5: With `wr_en` high and `wr_addr` at or above `NUM_CELLS`, no cell changes.
- R6: `cell_qn` is the bitwise complement of `cell_q` at all times.
- R7: With `WL_OUT_EN` = 1, `sel_n` is combinational from the write inputs. Bit `wr_addr` is 0 and every other bit is 1 when `wr_en` is high and the address is in range. In every other case all bits are 1. With `WL_OUT_EN` = 0, `sel_n` is tied to all ones.
- R8: A cell that has been written can be overwritten with the opposite value, and it then keeps that value over later cycles that do not address it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all cells |
| wr_en | input | 1 | Write enable; gates every word-line |
| wr_addr | input | ADDR_W (ceil(log2(NUM_CELLS)), at least 1) | Binary index of the cell to write |
| wr_bit | input | 1 | Data bit broadcast to all cells |
| cell_q | output | NUM_CELLS | Stored bit of each cell, bit i is cell i |
| cell_qn | output | NUM_CELLS | Complement of each stored bit |
| sel_n | output | NUM_CELLS | Active-low word-lines, bit i selects cell i |

## Verification
With the default of 12 cells, the bench sends addresses 12 to 15 with enable high and a mix of data bits. A decoder that compares only the low address bits, and so aliases those addresses onto real cells, would corrupt stored bits here. It also applies a live address and data bit while enable is low, which catches a word-line that skips the enable gate. It writes ones and then zeros into the same cells, with neighbours holding the opposite value. A cell that could only set, or a write that reached adjacent cells, would show up as a mismatch against the reference model on that clock. A reset in the middle of the run must clear a memory full of data, and the active-low word-line bus is compared against the current inputs before each clock edge.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;

  // Address width for a given cell count, never below one bit.
  function automatic int addr_width(input int cells);
    if (cells <= 2) return 1;
    return $clog2(cells);
  endfunction

endpackage

// File: rtl/cfgmem_decoder.sv
module cfgmem_decoder #(
  parameter int NUM_CELLS = 12,
  parameter int ADDR_W    = 4
) (
  input  logic                 en,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_CELLS-1:0] wl
);

  // One comparator per cell; an address with no cell behind it matches none.
  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_line
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);
    assign wl[i] = en && (addr == MY_ADDR);
  end

endmodule

// File: rtl/cfgmem_cell.sv
module cfgmem_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic wl,
  input  logic bl,
  output logic q,
  output logic qn
);

  logic store;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  store <= 1'b0;
    else if (wl) store <= bl;
  end

  assign q  = store;
  assign qn = ~store;

endmodule

// File: rtl/cfgmem_frame.sv
module cfgmem_frame
  import cfgmem_pkg::*;
#(
  parameter int  NUM_CELLS = 12,
  parameter bit  WL_OUT_EN = 1'b1,
  localparam int ADDR_W    = addr_width(NUM_CELLS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic                 wr_bit,
  output logic [NUM_CELLS-1:0] cell_q,
  output logic [NUM_CELLS-1:0] cell_qn,
  output logic [NUM_CELLS-1:0] sel_n
);

  logic [NUM_CELLS-1:0] wl;

  cfgmem_decoder #(
    .NUM_CELLS (NUM_CELLS),
    .ADDR_W    (ADDR_W)
  ) u_dec (
    .en   (wr_en),
    .addr (wr_addr),
    .wl   (wl)
  );

  // Shared bit-line: the same data bit reaches every cell.
  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    cfgmem_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .wl    (wl[i]),
      .bl    (wr_bit),
      .q     (cell_q[i]),
      .qn    (cell_qn[i])
    );
  end

  if (WL_OUT_EN) begin : g_wl_out
    assign sel_n = ~wl;
  end else begin : g_wl_tie
    assign sel_n = '1;
  end

endmodule

// File: rtl/cfgmem_frame_chk.sv
module cfgmem_frame_chk #(
  parameter int NUM_CELLS = 12,
  parameter int ADDR_W    = 4,
  parameter bit WL_OUT_EN = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic                 wr_bit,
  input logic [NUM_CELLS-1:0] cell_q,
  input logic [NUM_CELLS-1:0] cell_qn,
  input logic [NUM_CELLS-1:0] sel_n
);

  localparam int LIMIT = NUM_CELLS;

  logic in_range;
  assign in_range = int'(wr_addr) < LIMIT;

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |-> (cell_q == '0));

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_range) |=> (cell_q[$past(wr_addr)] == $past(wr_bit)));

  a_r3_single_change: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cell_q ^ $past(cell_q)) <= 1);

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cell_q));

  a_r5_oob_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_range) |=> $stable(cell_q));

  a_r6_complement: assert property (@(posedge clk) cell_qn == ~cell_q);

  a_r7_sel_onehot: assert property (@(posedge clk) $onehot0(~sel_n));

  a_r7_sel_gated: assert property (@(posedge clk) (!wr_en || !in_range) |-> (sel_n == '1));

endmodule

bind cfgmem_frame cfgmem_frame_chk #(
  .NUM_CELLS (NUM_CELLS),
  .ADDR_W    (ADDR_W),
  .WL_OUT_EN (WL_OUT_EN)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_bit  (wr_bit),
  .cell_q  (cell_q),
  .cell_qn (cell_qn),
  .sel_n   (sel_n)
);

// File: tb/cfgmem_frame_tb.sv
module cfgmem_frame_tb;

  localparam int N  = 12;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic          wr_bit = 1'b0;
  logic [N-1:0]  cell_q, cell_qn, sel_n;

  int checks = 0;
  int fails  = 0;
  bit model [N];

  always #4 clk = ~clk;

  cfgmem_frame #(.NUM_CELLS(N), .WL_OUT_EN(1'b1)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_bit  (wr_bit),
    .cell_q  (cell_q),
    .cell_qn (cell_qn),
    .sel_n   (sel_n)
  );

  function automatic logic [N-1:0] model_vec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = model[i];
    return v;
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Apply one write cycle, check word-lines before the edge and state after it.
  task automatic step(input string req, input logic en, input int addr, input logic d);
    logic [N-1:0] exp_sel;
    wr_en = en; wr_addr = AW'(addr); wr_bit = d;
    #1;
    exp_sel = '1;
    if (en && addr < N) exp_sel[addr] = 1'b0;
    check("R7", sel_n, exp_sel);
    @(posedge clk);
    if (en && addr < N) model[addr] = d;
    @(negedge clk);
    check(req, cell_q, model_vec());
    check("R6", cell_qn, ~model_vec());
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    #1;
    for (int i = 0; i < N; i++) model[i] = 1'b0;
    check("R1", cell_q, '0);
    check("R1", cell_qn, '1);
    check("R7", sel_n, '1);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [7:0] lfsr;
    #1;
    do_reset();
    // R2: set every cell in turn
    for (int i = 0; i < N; i++) step("R2", 1'b1, i, 1'b1);
    // R8: clear even cells, odd neighbours must stay 1 (R3)
    for (int i = 0; i < N; i += 2) step("R8", 1'b1, i, 1'b0);
    step("R3", 1'b1, 5, 1'b1);
    // R4: live address and data with enable low
    for (int i = 0; i < N; i++) step("R4", 1'b0, i, ~model[i]);
    // R5: out-of-range addresses with enable high
    for (int a = N; a < (1 << AW); a++) step("R5", 1'b1, a, 1'b1);
    for (int a = N; a < (1 << AW); a++) step("R5", 1'b1, a, 1'b0);
    // R8: flip cell 3 back and forth, then idle and confirm it holds
    step("R8", 1'b1, 3, 1'b1);
    step("R8", 1'b1, 3, 1'b0);
    step("R8", 1'b1, 3, 1'b1);
    for (int i = 0; i < 4; i++) step("R8", 1'b0, 3, 1'b0);
    // Mixed pseudo-random traffic, R3 via full compare
    lfsr = 8'hA5;
    for (int k = 0; k < 200; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step("R3", lfsr[7] | lfsr[6], int'(lfsr[3:0]), lfsr[5]);
    end
    // R1: reset with data loaded
    for (int i = 0; i < N; i++) step("R2", 1'b1, i, 1'b1);
    do_reset();
    step("R2", 1'b1, N - 1, 1'b1);
    step("R2", 1'b1, 0, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule